// File: doc/BRIEF.md
# Single-Precision Multiply Execution Unit

This unit executes a register-to-register single-precision multiply. An issue carries a 16-bit instruction word and the contents of the two source registers. When the word decodes as a multiply, the unit classifies both operands, chooses a special result or the rounded product, and one cycle later presents a write request for the destination register. The register file itself sits outside the unit.

The unit keeps three small bit groups. The cause group describes the most recent multiply. The flag group collects the sticky history of those causes. The enable group selects which exceptions request a trap. When a trap is requested, the destination write is withheld, but cause and flag still record what happened.

Top module: `fpmul_unit`

## Requirements
- R1: An issue is accepted only when `op_code[15:12]` is 4'hF and `op_code[3:0]` is 4'h2. Any other word produces no write and no trap, and leaves `cause_o` unchanged.
- R2: An accepted multiply presents its result exactly one clock later. `res_we` is high for one cycle and `res_idx` equals `op_code[11:8]`, the destination and first-source index n. The second source index m sits in `op_code[7:4]`.
- R3: Every accepted multiply clears the cause group before setting new bits. Cause bits are bit0 inexact, bit1 underflow, bit2 overflow, bit3 invalid and bit4 error. `flag_o[3:0]` is the sticky OR of `cause_o[3:0]`.
- R4: Operand checks follow a fixed priority: signalling NaN first, then quiet NaN, then denormal, then the zero/infinity cases. A NaN with fraction bit 22 set is signalling; a NaN with bit 22 clear is quiet.
- R5: A signalling NaN in either operand yields 32'h7FBFFFFF and sets the invalid cause.
- R6: A quiet NaN in either operand, with no signalling NaN present, yields 32'h7FBFFFFF and sets no cause.
- R7: A denormal operand, with no NaN present, sets only the error cause. It always requests a trap and never writes.
- R8: Zero times a normal or zero gives a zero, and infinity times a normal or infinity gives an infinity. In both cases the sign is the XOR of the operand signs. Zero times infinity yields 32'h7FBFFFFF with the invalid cause.
- R9: A product of two normals is rounded to nearest-even on a 24-bit significand. A rounded-off remainder sets the inexact cause.
- R10: A biased exponent of 255 or more yields a signed infinity with overflow and inexact. A biased exponent of 0 or less yields a signed zero with underflow and inexact.
- R11: `trap_o` pulses with the result when the error cause is set, when any cause bit [3:0] meets its enable bit, or whenever enable bit0 (inexact) is set. While `trap_o` is high, `res_we` stays low.
- R12: `en_load` loads `en_value` into the enable group. Enable bit positions match cause bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue strobe |
| op_code | input | 16 | Instruction word |
| opnd_n | input | 32 | Value of register n |
| opnd_m | input | 32 | Value of register m |
| en_load | input | 1 | Load strobe for the enable group |
| en_value | input | 4 | New enable bits |
| res_we | output | 1 | Destination write request |
| res_idx | output | 4 | Destination register index |
| res_data | output | 32 | Value to write |
| cause_o | output | 5 | Cause group of the last multiply |
| flag_o | output | 4 | Sticky exception flags |
| trap_o | output | 1 | Trap request |

## Verification
A fault in operand classification or priority shows up in the cycle after the issue, as a wrong result word, a wrong cause, or a wrong split between write and trap. A rounding or exponent fault changes only the low fraction bits or the exponent field of a single result, so the vectors include round-up, carry-out, overflow and tiny products. A corrupted flag or enable register stays hidden until a later multiply. Because of that, the flag value is compared after every result, and enabled operations follow disabled ones.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int FLT_W   = 1 + EXP_W + FRAC_W;
    localparam int CAUSE_W = 5;
    localparam int FLAG_W  = 4;

    localparam int C_INX = 0;
    localparam int C_UNF = 1;
    localparam int C_OVF = 2;
    localparam int C_INV = 3;
    localparam int C_ERR = 4;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fcls_e;
endpackage

// File: rtl/fpmul_classify.sv
module fpmul_classify
    import fpmul_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] op,
    output fcls_e          cls
);
    logic [EW-1:0] e_fld;
    logic [FW-1:0] f_fld;

    always_comb begin
        e_fld = op[EW+FW-1:FW];
        f_fld = op[FW-1:0];
        if (&e_fld) begin
            if (f_fld == '0)      cls = CLS_INF;
            else if (f_fld[FW-1]) cls = CLS_SNAN;
            else                  cls = CLS_QNAN;
        end else if (e_fld == '0) begin
            cls = (f_fld == '0) ? CLS_ZERO : CLS_DENORM;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpmul_core.sv
module fpmul_core
    import fpmul_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] a,
    input  logic [EW+FW:0] b,
    output logic [EW+FW:0] prod,
    output logic           ovf,
    output logic           unf,
    output logic           inx
);
    localparam int SIG_W  = FW + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EW + 2;
    localparam int BIAS   = (1 << (EW - 1)) - 1;
    localparam int EMAX   = (1 << EW) - 1;

    logic [SIG_W-1:0]  sig_a, sig_b, mant;
    logic [PROD_W-1:0] full;
    logic              hi, rnd, sticky, inc, carry, sgn;
    logic [SIG_W:0]    sum;
    logic signed [XW-1:0] e_sum;
    logic [FW-1:0]     frac;

    always_comb begin
        sgn    = a[EW+FW] ^ b[EW+FW];
        sig_a  = {1'b1, a[FW-1:0]};
        sig_b  = {1'b1, b[FW-1:0]};
        full   = PROD_W'(sig_a) * PROD_W'(sig_b);
        hi     = full[PROD_W-1];
        if (hi) begin
            mant   = full[PROD_W-1 -: SIG_W];
            rnd    = full[PROD_W-SIG_W-1];
            sticky = |full[PROD_W-SIG_W-2:0];
        end else begin
            mant   = full[PROD_W-2 -: SIG_W];
            rnd    = full[PROD_W-SIG_W-2];
            sticky = |full[PROD_W-SIG_W-3:0];
        end
        inc   = rnd & (sticky | mant[0]);
        sum   = {1'b0, mant} + (SIG_W+1)'(inc);
        carry = sum[SIG_W];
        frac  = carry ? '0 : sum[FW-1:0];
        e_sum = $signed(XW'(a[EW+FW-1:FW])) + $signed(XW'(b[EW+FW-1:FW]))
              - $signed(XW'(BIAS)) + $signed(XW'(hi)) + $signed(XW'(carry));
        ovf   = (e_sum >= $signed(XW'(EMAX)));
        unf   = (e_sum <= $signed(XW'(0)));
        inx   = rnd | sticky | ovf | unf;
        if (ovf)      prod = {sgn, {EW{1'b1}}, {FW{1'b0}}};
        else if (unf) prod = {sgn, {(EW+FW){1'b0}}};
        else          prod = {sgn, e_sum[EW-1:0], frac};
    end
endmodule

// File: rtl/fpmul_unit.sv
module fpmul_unit
    import fpmul_pkg::*;
#(
    parameter int EW    = EXP_W,
    parameter int FW    = FRAC_W,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [15:0]        op_code,
    input  logic [EW+FW:0]     opnd_n,
    input  logic [EW+FW:0]     opnd_m,
    input  logic               en_load,
    input  logic [FLAG_W-1:0]  en_value,
    output logic               res_we,
    output logic [IDX_W-1:0]   res_idx,
    output logic [EW+FW:0]     res_data,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [FLAG_W-1:0]  flag_o,
    output logic               trap_o
);
    localparam int W = EW + FW + 1;
    localparam logic [W-1:0] DFLT_QNAN = {1'b0, {EW{1'b1}}, 1'b0, {(FW-1){1'b1}}};

    typedef struct packed {
        logic               wr;
        logic [IDX_W-1:0]   idx;
        logic [W-1:0]       data;
        logic [CAUSE_W-1:0] cause;
        logic [FLAG_W-1:0]  flag;
        logic [FLAG_W-1:0]  en;
        logic               trap;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] opnd [2];
    fcls_e        cls  [2];
    logic [W-1:0] core_res;
    logic         core_ovf, core_unf, core_inx;

    assign opnd[0] = opnd_n;
    assign opnd[1] = opnd_m;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpmul_classify #(.EW(EW), .FW(FW)) u_cls (
            .op  (opnd[gi]),
            .cls (cls[gi])
        );
    end

    fpmul_core #(.EW(EW), .FW(FW)) u_core (
        .a    (opnd_n),
        .b    (opnd_m),
        .prod (core_res),
        .ovf  (core_ovf),
        .unf  (core_unf),
        .inx  (core_inx)
    );

    logic               acc, any_snan, any_qnan, any_dn, any_zero, any_inf, sgn;
    logic [CAUSE_W-1:0] c;
    logic [W-1:0]       r;
    logic               trp;

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        st_d.trap = 1'b0;
        acc      = op_valid && (op_code[15:12] == 4'hF) && (op_code[3:0] == 4'h2);
        any_snan = (cls[0] == CLS_SNAN)   || (cls[1] == CLS_SNAN);
        any_qnan = (cls[0] == CLS_QNAN)   || (cls[1] == CLS_QNAN);
        any_dn   = (cls[0] == CLS_DENORM) || (cls[1] == CLS_DENORM);
        any_zero = (cls[0] == CLS_ZERO)   || (cls[1] == CLS_ZERO);
        any_inf  = (cls[0] == CLS_INF)    || (cls[1] == CLS_INF);
        sgn      = opnd_n[W-1] ^ opnd_m[W-1];
        c        = '0;
        r        = st_q.data;

        if (any_snan) begin
            r        = DFLT_QNAN;
            c[C_INV] = 1'b1;
        end else if (any_qnan) begin
            r        = DFLT_QNAN;
        end else if (any_dn) begin
            c[C_ERR] = 1'b1;
        end else if (any_zero && any_inf) begin
            r        = DFLT_QNAN;
            c[C_INV] = 1'b1;
        end else if (any_inf) begin
            r        = {sgn, {EW{1'b1}}, {FW{1'b0}}};
        end else if (any_zero) begin
            r        = {sgn, {(W-1){1'b0}}};
        end else begin
            r        = core_res;
            c[C_INX] = core_inx;
            c[C_OVF] = core_ovf;
            c[C_UNF] = core_unf;
        end

        trp = c[C_ERR] | (|(c[FLAG_W-1:0] & st_q.en)) | st_q.en[C_INX];

        if (acc) begin
            st_d.cause = c;
            st_d.flag  = st_q.flag | c[FLAG_W-1:0];
            st_d.trap  = trp;
            st_d.wr    = ~trp;
            st_d.idx   = op_code[11:8];
            if (!trp) st_d.data = r;
        end
        if (en_load) st_d.en = en_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_we   = st_q.wr;
    assign res_idx  = st_q.idx;
    assign res_data = st_q.data;
    assign cause_o  = st_q.cause;
    assign flag_o   = st_q.flag;
    assign trap_o   = st_q.trap;
endmodule

// File: rtl/fpmul_unit_chk.sv
module fpmul_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [15:0] op_code,
    input logic        res_we,
    input logic [4:0]  cause_o,
    input logic [3:0]  flag_o,
    input logic        trap_o
);
    logic acc;
    assign acc = op_valid && (op_code[15:12] == 4'hF) && (op_code[3:0] == 4'h2);

    p_no_write_on_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !res_we);

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (res_we || trap_o));

    p_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!res_we && !trap_o && $stable(cause_o)));

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    p_flag_covers_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((flag_o & cause_o[3:0]) == cause_o[3:0]));

    p_error_traps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (!cause_o[4] || trap_o));
endmodule

bind fpmul_unit fpmul_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .res_we   (res_we),
    .cause_o  (cause_o),
    .flag_o   (flag_o),
    .trap_o   (trap_o)
);

// File: tb/fpmul_unit_bench.sv
module fpmul_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = '0;
    logic [31:0] opnd_n = '0, opnd_m = '0;
    logic        en_load = 1'b0;
    logic [3:0]  en_value = '0;
    logic        res_we, trap_o;
    logic [3:0]  res_idx, flag_o;
    logic [31:0] res_data;
    logic [4:0]  cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        wr;
        logic [3:0]  idx;
        logic [31:0] data;
        logic [4:0]  cause;
        logic [3:0]  flag;
        logic        trap;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] exp_flag = '0;
    logic [4:0] last_cause = '0;

    always #(CLK_P/2) clk = ~clk;

    fpmul_unit u_fpmul_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_n(opnd_n), .opnd_m(opnd_m), .en_load(en_load), .en_value(en_value),
        .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
        .cause_o(cause_o), .flag_o(flag_o), .trap_o(trap_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: predicts from requirements and queues the expectation
    task automatic issue(input logic [15:0] opc, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] r, input logic [4:0] c, input logic trp, input string tag);
        exp_t e;
        bit   acc;
        acc = (opc[15:12] == 4'hF) && (opc[3:0] == 4'h2);
        if (acc) begin
            exp_flag   = exp_flag | c[3:0];
            last_cause = c;
        end
        e.wr    = acc && !trp;
        e.idx   = opc[11:8];
        e.data  = r;
        e.cause = last_cause;
        e.flag  = exp_flag;
        e.trap  = acc && trp;
        e.tag   = tag;
        @(negedge clk);
        sb.push_back(e);
        op_valid = 1'b1; op_code = opc; opnd_n = a; opnd_m = b;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_en(input logic [3:0] v);
        @(negedge clk);
        en_load = 1'b1; en_value = v;
        @(negedge clk);
        en_load = 1'b0;
    endtask

    // monitor: pops one expectation per issued word
    initial begin
        forever begin
            @(posedge clk);
            if (op_valid) begin
                exp_t e;
                #1;
                e = sb.pop_front();
                check(res_we == e.wr, {e.tag, " write"}, 32'(res_we), 32'(e.wr));
                check(trap_o == e.trap, {e.tag, " trap"}, 32'(trap_o), 32'(e.trap));
                check(cause_o == e.cause, {e.tag, " cause R3"}, 32'(cause_o), 32'(e.cause));
                check(flag_o == e.flag, {e.tag, " flag R3"}, 32'(flag_o), 32'(e.flag));
                if (e.wr) begin
                    check(res_data == e.data, {e.tag, " data"}, res_data, e.data);
                    check(res_idx == e.idx, {e.tag, " index R2"}, 32'(res_idx), 32'(e.idx));
                end
                @(posedge clk); #1;
                check(!res_we && !trap_o, {e.tag, " pulse width R2"}, 32'({res_we, trap_o}), 32'(0));
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!res_we && !trap_o && cause_o == 0 && flag_o == 0, "reset state",
              {res_we, trap_o, flag_o, cause_o}, 32'(0));
        rst_n = 1'b1;
        issue(16'hF312, 32'h3FC00000, 32'h40000000, 32'h40400000, 5'b00000, 0, "R2 R9 exact 1.5*2");
        issue(16'hF452, 32'h3FC00001, 32'h3FC00001, 32'h40100002, 5'b00001, 0, "R9 round up");
        issue(16'hF562, 32'h3F800001, 32'h3F800001, 32'h3F800002, 5'b00001, 0, "R9 round down");
        issue(16'hF7A2, 32'hC0000000, 32'h40400000, 32'hC0C00000, 5'b00000, 0, "R9 negative, R3 cause cleared");
        issue(16'hF102, 32'h7F000000, 32'h7F000000, 32'h7F800000, 5'b00101, 0, "R10 overflow");
        issue(16'hF212, 32'h80800000, 32'h3F000000, 32'h80000000, 5'b00011, 0, "R10 underflow");
        issue(16'hF322, 32'h80000000, 32'h40000000, 32'h80000000, 5'b00000, 0, "R8 zero*normal");
        issue(16'hF432, 32'h00000000, 32'h80000000, 32'h80000000, 5'b00000, 0, "R8 zero*zero");
        issue(16'hF542, 32'hFF800000, 32'hC0000000, 32'h7F800000, 5'b00000, 0, "R8 inf*normal");
        issue(16'hF652, 32'h7F800000, 32'hFF800000, 32'hFF800000, 5'b00000, 0, "R8 inf*inf");
        issue(16'hF762, 32'h00000000, 32'hFF800000, 32'h7FBFFFFF, 5'b01000, 0, "R8 zero*inf");
        issue(16'hF872, 32'h7FC00000, 32'h7F800001, 32'h7FBFFFFF, 5'b01000, 0, "R4 R5 snan over qnan");
        issue(16'hF982, 32'h00000001, 32'hFFC00001, 32'h7FBFFFFF, 5'b01000, 0, "R4 R5 snan over denorm");
        issue(16'hFA92, 32'h7F800001, 32'h00000001, 32'h7FBFFFFF, 5'b00000, 0, "R4 R6 qnan over denorm");
        issue(16'hFBA2, 32'h00000001, 32'h3F800000, 32'h0, 5'b10000, 1, "R7 denormal error");
        issue(16'hF313, 32'h3FC00000, 32'h40000000, 32'h0, 5'b00000, 0, "R1 bad opcode ignored");
        issue(16'h0312, 32'h3FC00000, 32'h40000000, 32'h0, 5'b00000, 0, "R1 bad prefix ignored");
        load_en(4'b0001);
        issue(16'hFC12, 32'h3FC00000, 32'h40000000, 32'h0, 5'b00000, 1, "R11 R12 inexact enable traps always");
        load_en(4'b1000);
        issue(16'hFD12, 32'h00000000, 32'h7F800000, 32'h0, 5'b01000, 1, "R11 R12 invalid enabled");
        issue(16'hFE12, 32'h3FC00000, 32'h40000000, 32'h40400000, 5'b00000, 0, "R11 no trap without cause");
        issue(16'hFF12, 32'h7F000000, 32'h7F000000, 32'h7F800000, 5'b00101, 0, "R11 overflow not enabled");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule